// File: doc/BRIEF.md
# Warp lane shuffle unit

This block exchanges 32-bit values between the 32 lanes of a SIMD group in one issue. Each lane brings a data word, a source index and a control word. A shared two-bit operation code picks how a lane names the lane it reads from. In indexed mode the lane reads an absolute lane number inside its segment. In down mode it reads its own number plus the index. In up mode it reads its own number minus the index. In butterfly mode it reads its own number XOR the index.

The control word holds two fields. A clamp value in bits 4:0 and a segment mask in bits 23:8 split the group into sub-groups. Together they give every lane a lower and an upper lane bound. For each lane the block forms a source lane number and a bounds predicate, then reads the source lane's data through a crossbar. A lane whose predicate is false keeps its own value.

The results and a one-cycle done pulse are registered on the clock edge that samples the issue strobe. All lanes are treated as active. The control word and the index can each come from a shared immediate or from a per-lane operand.

Top module: `lane_xchg_unit`

## Requirements
- R1: With mode code 1 (down) the source lane is lane+index. With code 2 (up) it is lane-index. With code 3 (butterfly) it is lane XOR index. All arithmetic is 32-bit and wraps.
- R2: With mode code 0 (indexed) the source lane is (index AND NOT seg) OR lo.
- R3: clamp is control bits 4:0 and seg is control bits 23:8, both zero-extended. lo = lane AND seg, and hi = lo OR (clamp AND NOT seg). Control bits 7:5 and 31:24 have no effect.
- R4: In up mode the predicate is 1 when src >= lo. In every other mode it is 1 when src <= hi. Both are unsigned 32-bit compares.
- R5: When the predicate is 1, the lane's output is the input data of lane src[4:0].
- R6: When the predicate is 0, the lane's output is its own input data.
- R7: When mask_use_imm is 1, every lane uses mask_imm; when it is 0, lane i uses mask_lane[32*i+:32]. idx_use_imm selects between idx_imm and idx_lane in the same way.
- R8: data_out, pred_out and done are updated at the clock edge that samples issue=1. done is 1 for exactly the cycle after each issue.
- R9: A cycle without issue leaves data_out and pred_out unchanged and drives done to 0.
- R10: Under synchronous active-low reset, data_out and pred_out are 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Issue strobe; results are registered on this edge |
| mode | input | 2 | Addressing mode: 0 indexed, 1 down, 2 up, 3 butterfly |
| mask_use_imm | input | 1 | 1: use mask_imm for all lanes; 0: use mask_lane |
| mask_imm | input | 32 | Shared control word |
| mask_lane | input | 1024 | Per-lane control words, lane i at bits 32*i+:32 |
| idx_use_imm | input | 1 | 1: use idx_imm for all lanes; 0: use idx_lane |
| idx_imm | input | 32 | Shared source index |
| idx_lane | input | 1024 | Per-lane source indices, lane i at bits 32*i+:32 |
| data_in | input | 1024 | Lane data, lane i at bits 32*i+:32 |
| data_out | output | 1024 | Registered exchanged data |
| pred_out | output | 32 | Registered per-lane bounds predicate |
| done | output | 1 | One-cycle pulse marking fresh results |

## Verification
The main sweep crosses all four modes with every immediate index from 0 to 33 and with six control words. The control words cover one full-width group, sub-groups of 8, 4 and 2 lanes, a clamp of zero, and an all-ones segment mask. These cases separate the segment arithmetic from the clamp arithmetic. Indices past 31 and up-shifts past lane 0 show whether the compares are unsigned 32-bit compares and whether only the low five bits drive the crossbar. A control word with junk in the unused bits must give the same results as the clean word. A pass with per-lane control words and per-lane indices shows that each lane reads its own operands. The data pattern changes on every issue, so stale outputs and the own-value fallback can both be told apart from a correct crossbar read.

// File: rtl/lane_xchg_pkg.sv
// Shared constants and the mode encoding for the lane shuffle unit.
// Assumes a 32-bit control word with the clamp at the bottom and the
// segment mask field starting at bit 8.
package lane_xchg_pkg;
    localparam int CTRL_W   = 32;
    localparam int CLAMP_W  = 5;
    localparam int SEG_LSB  = 8;
    localparam int SEG_W    = 16;

    typedef enum logic [1:0] {
        XM_INDEXED = 2'd0,
        XM_DOWN    = 2'd1,
        XM_UP      = 2'd2,
        XM_BFLY    = 2'd3
    } xchg_mode_e;
endpackage

// File: rtl/lane_xchg_addr.sv
// Per-lane source address generator.
// For a fixed lane number it derives the segment bounds from the control
// word, forms the source lane for the selected mode and raises the
// bounds predicate. Purely combinational; arithmetic is 32-bit unsigned.
module lane_xchg_addr
    import lane_xchg_pkg::*;
#(
    parameter int LANE_ID = 0,
    parameter int SEL_W   = 5
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [CTRL_W-1:0] index,
    input  logic [1:0]        mode,
    output logic [SEL_W-1:0]  src_sel,
    output logic              in_bounds
);
    localparam logic [CTRL_W-1:0] LANE_V = CTRL_W'(LANE_ID);

    logic [CTRL_W-1:0] clamp_v, seg_v, lo_v, hi_v, src_v;

    // field extraction and segment bounds
    always_comb begin
        clamp_v = CTRL_W'(ctrl[CLAMP_W-1:0]);
        seg_v   = CTRL_W'(ctrl[SEG_LSB +: SEG_W]);
        lo_v    = LANE_V & seg_v;
        hi_v    = lo_v | (clamp_v & ~seg_v);
    end

    // source lane per addressing mode, with the bounds test
    always_comb begin
        unique case (xchg_mode_e'(mode))
            XM_INDEXED: src_v = (index & ~seg_v) | lo_v;
            XM_DOWN:    src_v = LANE_V + index;
            XM_UP:      src_v = LANE_V - index;
            default:    src_v = LANE_V ^ index;
        endcase
        if (xchg_mode_e'(mode) == XM_UP) in_bounds = (src_v >= lo_v);
        else                             in_bounds = (src_v <= hi_v);
        src_sel = src_v[SEL_W-1:0];
    end

    // sanity checks on the address relations
    always_comb begin
        // R2
        idx_in_segment_chk: assert (xchg_mode_e'(mode) != XM_INDEXED || (src_v & seg_v) == lo_v);
        // R1
        bfly_involution_chk: assert (xchg_mode_e'(mode) != XM_BFLY || (src_v ^ index) == LANE_V);
        // R3
        bounds_order_chk: assert (hi_v >= lo_v);
    end
endmodule

// File: rtl/lane_xchg_xbar.sv
// Full crossbar: each output lane reads the input lane named by its
// select. Assumes LANES is a power of two addressed by SEL_W bits.
module lane_xchg_xbar #(
    parameter int LANES = 32,
    parameter int DW    = 32,
    parameter int SEL_W = 5
) (
    input  logic [LANES*DW-1:0]    data_in,
    input  logic [LANES*SEL_W-1:0] sel,
    output logic [LANES*DW-1:0]    data_out
);
    // one multiplexer per output lane
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            data_out[i*DW +: DW] = data_in[int'(sel[i*SEL_W +: SEL_W])*DW +: DW];
        end
    end
endmodule

// File: rtl/lane_xchg_unit.sv
// Lane shuffle unit top. Picks the per-lane control word and index
// (shared immediate or per-lane operand), computes a source lane and
// bounds predicate per lane, reads through the crossbar, falls back to the
// lane's own value when out of bounds, and registers results on issue.
// All lanes are assumed active. Reset is synchronous, active low.
module lane_xchg_unit
    import lane_xchg_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue,
    input  logic [1:0]             mode,
    input  logic                   mask_use_imm,
    input  logic [CTRL_W-1:0]      mask_imm,
    input  logic [LANES*CTRL_W-1:0] mask_lane,
    input  logic                   idx_use_imm,
    input  logic [CTRL_W-1:0]      idx_imm,
    input  logic [LANES*CTRL_W-1:0] idx_lane,
    input  logic [LANES*DW-1:0]    data_in,
    output logic [LANES*DW-1:0]    data_out,
    output logic [LANES-1:0]       pred_out,
    output logic                   done
);
    localparam int SEL_W = $clog2(LANES);

    logic [LANES*SEL_W-1:0] sel_w;
    logic [LANES-1:0]       pred_w;
    logic [LANES*DW-1:0]    xbar_w;
    logic [LANES*DW-1:0]    next_w;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CTRL_W-1:0] ctrl_g, idx_g;

        // operand source selection for this lane
        always_comb begin
            ctrl_g = mask_use_imm ? mask_imm : mask_lane[g*CTRL_W +: CTRL_W];
            idx_g  = idx_use_imm  ? idx_imm  : idx_lane[g*CTRL_W +: CTRL_W];
        end

        lane_xchg_addr #(.LANE_ID(g), .SEL_W(SEL_W)) u_addr (
            .ctrl     (ctrl_g),
            .index    (idx_g),
            .mode     (mode),
            .src_sel  (sel_w[g*SEL_W +: SEL_W]),
            .in_bounds(pred_w[g])
        );

        // out-of-bounds lanes keep their own value
        always_comb begin
            next_w[g*DW +: DW] = pred_w[g] ? xbar_w[g*DW +: DW] : data_in[g*DW +: DW];
        end

        // R6
        own_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && !pred_w[g]) |=> (data_out[g*DW +: DW] == $past(data_in[g*DW +: DW])));
    end

    lane_xchg_xbar #(.LANES(LANES), .DW(DW), .SEL_W(SEL_W)) u_xbar (
        .data_in (data_in),
        .sel     (sel_w),
        .data_out(xbar_w)
    );

    // result registers, loaded on issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            pred_out <= '0;
            done     <= 1'b0;
        end else begin
            done <= issue;
            if (issue) begin
                data_out <= next_w;
                pred_out <= pred_w;
            end
        end
    end

    // R8
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) issue |=> done);
    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !issue |=> !done);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(data_out) && $stable(pred_out)));
endmodule

// File: tb/lane_xchg_unit_tb.sv
// Sweep bench: every mode, indices 0..33, several control words, plus
// per-lane operand and junk-bit passes; expected values computed here.
module lane_xchg_unit_tb;
    localparam int L = 32;
    localparam int W = 32;

    logic clk = 0, rst_n = 0, issue = 0;
    logic [1:0] mode = 0;
    logic mask_use_imm = 1, idx_use_imm = 1;
    logic [31:0] mask_imm = 0, idx_imm = 0;
    logic [L*32-1:0] mask_lane = '0, idx_lane = '0;
    logic [L*W-1:0] data_in = '0;
    logic [L*W-1:0] data_out;
    logic [L-1:0] pred_out;
    logic done;
    int checks = 0, fails = 0, nissue = 0;

    always #5 clk = ~clk;

    lane_xchg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .mode(mode),
        .mask_use_imm(mask_use_imm), .mask_imm(mask_imm), .mask_lane(mask_lane),
        .idx_use_imm(idx_use_imm), .idx_imm(idx_imm), .idx_lane(idx_lane),
        .data_in(data_in), .data_out(data_out), .pred_out(pred_out), .done(done)
    );

    function automatic void model(input int lane, input logic [31:0] m, input logic [31:0] ix,
                                  input logic [1:0] md, output logic [31:0] src, output bit p);
        logic [31:0] ln, cl, sg, lo, hi;
        ln = 32'(lane);
        cl = m & 32'h1F;
        sg = (m >> 8) & 32'hFFFF;
        lo = ln & sg;
        hi = lo | (cl & ~sg);
        case (md)
            2'd0: src = (ix & ~sg) | lo;
            2'd1: src = ln + ix;
            2'd2: src = ln - ix;
            default: src = ln ^ ix;
        endcase
        p = (md == 2'd2) ? (src >= lo) : (src <= hi);
    endfunction

    task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    // drive one issue, then verify all lanes and the done pulse
    task automatic do_issue(input string tg);
        logic [L*W-1:0] din;
        @(negedge clk);
        nissue++;
        for (int i = 0; i < L; i++)
            data_in[i*W +: W] = 32'h5A00_0000 ^ (32'(nissue) << 12) ^ (32'(i) * 32'h0001_0203);
        din = data_in;
        issue = 1;
        @(negedge clk);
        issue = 0;
        chk(done == 1'b1, "R8 done", 32'(done), 32'd1);
        for (int i = 0; i < L; i++) begin
            logic [31:0] m, ix, src, exp;
            bit p;
            m  = mask_use_imm ? mask_imm : mask_lane[i*32 +: 32];
            ix = idx_use_imm ? idx_imm : idx_lane[i*32 +: 32];
            model(i, m, ix, mode, src, p);
            exp = p ? din[int'(src[4:0])*W +: W] : din[i*W +: W];
            chk(pred_out[i] == p, $sformatf("%s/R4 pred lane %0d mode %0d", tg, i, mode),
                32'(pred_out[i]), 32'(p));
            chk(data_out[i*W +: W] == exp,
                $sformatf("%s/%s data lane %0d mode %0d", tg, p ? "R5" : "R6", i, mode),
                data_out[i*W +: W], exp);
        end
    endtask

    initial begin
        logic [31:0] masks [6];
        logic [L*W-1:0] keep_d;
        logic [L-1:0] keep_p;
        masks[0] = 32'h0000_001F; // one group of 32
        masks[1] = 32'h0000_1807; // groups of 8
        masks[2] = 32'h0000_1C03; // groups of 4
        masks[3] = 32'h0000_1E01; // groups of 2
        masks[4] = 32'h0000_0000; // clamp 0
        masks[5] = 32'h00FF_FF1F; // all-ones segment
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(done == 1'b0, "R10 done", 32'(done), 32'd0);
        chk(pred_out == '0, "R10 pred", pred_out, 32'd0);
        chk(data_out == '0, "R10 data", data_out[31:0], 32'd0);
        rst_n = 1;
        // main sweep: R1 and R2 by mode
        for (int md = 0; md < 4; md++)
            for (int mi = 0; mi < 6; mi++)
                for (int ix = 0; ix < 34; ix++) begin
                    mode = 2'(md);
                    mask_imm = masks[mi];
                    idx_imm = 32'(ix);
                    do_issue(md == 0 ? "R2" : "R1");
                end
        // R3: junk outside the clamp and segment fields is ignored
        for (int md = 0; md < 4; md++)
            for (int ix = 0; ix < 34; ix += 3) begin
                mode = 2'(md);
                mask_imm = 32'hA5_0000E0 | masks[1];
                idx_imm = 32'(ix);
                do_issue("R3");
            end
        // R7: per-lane control words and indices
        mask_use_imm = 0;
        idx_use_imm = 0;
        for (int k = 0; k < 8; k++)
            for (int md = 0; md < 4; md++) begin
                mode = 2'(md);
                for (int i = 0; i < L; i++) begin
                    mask_lane[i*32 +: 32] = masks[(i + k) % 6];
                    idx_lane[i*32 +: 32]  = 32'((i * 7 + k * 5) % 37);
                end
                do_issue("R7");
            end
        // R7: immediate selected while lane operands differ
        mask_use_imm = 1;
        idx_use_imm = 1;
        mask_imm = masks[2];
        idx_imm = 32'd3;
        mode = 2'd3;
        do_issue("R7");
        // R9: no issue holds outputs, done drops
        keep_d = data_out;
        keep_p = pred_out;
        data_in = ~data_in;
        mode = 2'd1;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R9 done", 32'(done), 32'd0);
        chk(data_out == keep_d, "R9 data", data_out[31:0], keep_d[31:0]);
        chk(pred_out == keep_p, "R9 pred", pred_out, keep_p);
        // R10 reset again clears
        rst_n = 0;
        @(negedge clk);
        chk(data_out == '0 && pred_out == '0 && !done, "R10 reclear", data_out[31:0], 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule